// File: doc/BRIEF.md
# JTAG Debug Command Shifter and Decoder

This block is the data path of a debug port that sits behind a JTAG TAP controller. It runs on TCK and uses the TAP's Capture-DR, Shift-DR and Update-DR strobes. Each data-register scan is one of two kinds. The block starts in the short kind: an 8-bit command. A long kind, a 16-bit data transfer, follows only when the latched command names a data register that the current direction and mode allow.

A latched command has four parts: a 5-bit target code, a direction, an execute request and an exit request. The block drives a one-hot target select, a write strobe and a write bus toward a small set of debug registers. For reads, the value on the read bus is loaded into the shifter at capture time and shifted out on TDO. Accesses that break the direction or mode rules are dropped and set a sticky error flag. One target code is an action that clears the debug counter without a data transfer.

Top module: `dbg_cmd_port`

## Requirements
- R1: On each rising TCK edge with Shift-DR high, TDI enters the most significant bit of the active shifter length. On each falling edge, TDO takes the shifter's least significant bit, so read data leaves LSB first.
- R2: A command byte has the read/write bit at bit 7 (1 = read, 0 = write), GO at bit 6, EX at bit 5 and the target code at bits 4:0.
- R3: After a command is latched on Update-DR, `xfer_long` goes high, making the next scan 16 bits, only for a legal data-register access. After every other command it stays low, and the next scan is again an 8-bit command. `xfer_long` returns low at the Update-DR of the data scan.
- R4: During a legal access, `reg_sel` is one-hot with this bit map: bit0 = code 00001 (counter, read/write), bit1 = 00010 (control, read/write), bit2 = 00100 (breakpoint address, write-only), bit3 = 01000 (bus transfer, read-only), bit4 = 01001 (program data, read/write), bit5 = 01010 (fetch address, read-only), bit6 = 10000 (execute address, read-only), bit7 = 10001 (address FIFO, read-only), bit8 = 10011 (decode address, read-only). For a read, `rd_data` is loaded into the shifter at Capture-DR.
- R5: For a legal write, the Update-DR of the data scan causes a one-cycle `wr_en` pulse. During that pulse, `wr_data` holds the 16 shifted bits and `reg_sel` holds the target.
- R6: A command with GO and EX both set gives a one-cycle `exit_req` pulse. GO set with EX clear gives a one-cycle `exec_req` pulse. The two pulses never occur together.
- R7: Target code 01100 gives a one-cycle `cnt_clr` pulse when the command is latched and starts no data scan.
- R8: Target code 00000 and all reserved codes select nothing, start no data scan and leave `err_flag` unchanged.
- R9: A write to a read-only target, a read of the write-only target or a write to an address-trace target is ignored: there is no data scan and no `wr_en`. `err_flag` is set and stays set until reset.
- R10: Codes 01000 and 01001 are legal only while `debug_mode` is high. Codes 01010, 10000, 10001 and 10011 are legal only while `fifo_halted` is high. These inputs are sampled when the command is latched. An access outside these conditions is handled as in R9.
- R11: After synchronous active-low reset, `tdo`, `err_flag`, `xfer_long`, `reg_sel` and all pulse outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| debug_mode | input | 1 | Core is in debug state |
| fifo_halted | input | 1 | Address trace FIFO is frozen |
| rd_data | input | 16 | Read value of the target named by reg_sel |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| xfer_long | output | 1 | Next scan is a 16-bit data transfer |
| reg_sel | output | 9 | One-hot target select |
| wr_en | output | 1 | One-cycle write strobe |
| wr_data | output | 16 | Write value |
| exec_req | output | 1 | Execute-one-instruction pulse |
| exit_req | output | 1 | Leave-debug pulse |
| cnt_clr | output | 1 | Counter clear pulse |
| err_flag | output | 1 | Sticky illegal-access flag |

## Verification
The hardest cases to reach are the mode-gated rejections. The mode inputs count only at the moment of command latch, and once the sticky flag is set it hides any later illegal access. The bench therefore sets `debug_mode` and `fifo_halted` before the Update-DR of each command. It resets the block before each rejection that must show the flag rising. For the rejections that follow, it checks that `xfer_long` stays low and that no write pulse appears. It then issues the same command again with the mode satisfied, to show the gate works in both directions.

// File: rtl/dbg_pkg.sv
// Shared widths and the decoded-target record for the debug command port.
package dbg_pkg;
    localparam int CMD_W  = 8;
    localparam int DATA_W = 16;
    localparam int SEL_W  = 5;
    localparam int NREG   = 9;
    localparam int IDX_W  = $clog2(NREG);

    // Result of decoding a 5-bit target code.
    typedef struct packed {
        logic             hit;        // names a data register
        logic [IDX_W-1:0] idx;        // bit position in the one-hot select
        logic             rd_ok;      // readable
        logic             wr_ok;      // writable
        logic             need_dbg;   // legal only in debug mode
        logic             need_halt;  // legal only with trace FIFO frozen
        logic             clr;        // counter-clear action
    } sel_dec_t;
endpackage

// File: rtl/dbg_sel_decode.sv
// Combinational decoder from a target code to access attributes.
// Assumes: unused and reserved codes decode to all-zero (no target, no action).
module dbg_sel_decode
    import dbg_pkg::*;
(
    input  logic [SEL_W-1:0] code,
    output sel_dec_t         dec
);
    // Map each code to its target index, directions and mode conditions.
    always_comb begin
        dec = '0;
        unique case (code)
            5'b00001: begin dec.hit = 1'b1; dec.idx = 4'd0; dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; end
            5'b00010: begin dec.hit = 1'b1; dec.idx = 4'd1; dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; end
            5'b00100: begin dec.hit = 1'b1; dec.idx = 4'd2; dec.wr_ok = 1'b1; end
            5'b01000: begin dec.hit = 1'b1; dec.idx = 4'd3; dec.rd_ok = 1'b1; dec.need_dbg = 1'b1; end
            5'b01001: begin dec.hit = 1'b1; dec.idx = 4'd4; dec.rd_ok = 1'b1; dec.wr_ok = 1'b1;
                            dec.need_dbg = 1'b1; end
            5'b01010: begin dec.hit = 1'b1; dec.idx = 4'd5; dec.rd_ok = 1'b1; dec.need_halt = 1'b1; end
            5'b10000: begin dec.hit = 1'b1; dec.idx = 4'd6; dec.rd_ok = 1'b1; dec.need_halt = 1'b1; end
            5'b10001: begin dec.hit = 1'b1; dec.idx = 4'd7; dec.rd_ok = 1'b1; dec.need_halt = 1'b1; end
            5'b10011: begin dec.hit = 1'b1; dec.idx = 4'd8; dec.rd_ok = 1'b1; dec.need_halt = 1'b1; end
            5'b01100: begin dec.clr = 1'b1; end
            default:  begin dec = '0; end
        endcase
    end
endmodule

// File: rtl/dbg_shifter.sv
// Variable-length DR shifter: CMD_W bits in command phase, DATA_W bits in data phase.
// Assumes: capture, shift and update strobes are mutually exclusive (TAP guarantees it).
module dbg_shifter #(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              tdi,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              long_mode,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] sh_q,
    output logic              tdo
);
    logic [DATA_W-1:0] sh_short;
    logic [DATA_W-1:0] sh_long;

    // Next shifter value for each length; new bit enters the top of the active window.
    always_comb begin
        sh_long  = {tdi, sh_q[DATA_W-1:1]};
        sh_short = '0;
        sh_short[CMD_W-1:0] = {tdi, sh_q[CMD_W-1:1]};
    end

    // Parallel load on capture, serial shift on Shift-DR.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (capture_en) begin
            sh_q <= load_val;
        end else if (shift_en) begin
            sh_q <= long_mode ? sh_long : sh_short;
        end
    end

    // Present the LSB on the falling edge.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo <= 1'b0;
        end else begin
            tdo <= sh_q[0];
        end
    end
endmodule

// File: rtl/dbg_cmd_ctrl.sv
// Command latch and data-phase sequencer: judges legality, drives select,
// write strobe and the one-cycle request pulses.
// Assumes: debug_mode and fifo_halted are stable around Update-DR.
module dbg_cmd_ctrl
    import dbg_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              update_en,
    input  logic              debug_mode,
    input  logic              fifo_halted,
    input  logic [DATA_W-1:0] sh_q,
    input  sel_dec_t          dec,
    output logic              xfer_long,
    output logic              rd_dir,
    output logic [NREG-1:0]   reg_sel,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              exec_req,
    output logic              exit_req,
    output logic              cnt_clr,
    output logic              err_flag
);
    localparam int RW_BIT = CMD_W - 1;
    localparam int GO_BIT = CMD_W - 2;
    localparam int EX_BIT = CMD_W - 3;

    logic            cmd_rd;
    logic            cmd_go;
    logic            cmd_ex;
    logic            access_ok;
    logic [NREG-1:0] sel_hot;

    // Split the freshly shifted command byte.
    assign cmd_rd = sh_q[RW_BIT];
    assign cmd_go = sh_q[GO_BIT];
    assign cmd_ex = sh_q[EX_BIT];

    // One-hot form of the decoded index.
    for (genvar g = 0; g < NREG; g++) begin : g_hot
        assign sel_hot[g] = (dec.idx == IDX_W'(g));
    end

    // Direction and mode legality of the addressed target.
    assign access_ok = (cmd_rd ? dec.rd_ok : dec.wr_ok)
                     && (!dec.need_dbg  || debug_mode)
                     && (!dec.need_halt || fifo_halted);

    // Latch commands, run the data phase and produce pulses.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            xfer_long <= 1'b0;
            rd_dir    <= 1'b0;
            reg_sel   <= '0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
            exec_req  <= 1'b0;
            exit_req  <= 1'b0;
            cnt_clr   <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            exec_req <= 1'b0;
            exit_req <= 1'b0;
            cnt_clr  <= 1'b0;
            if (wr_en) begin
                reg_sel <= '0;
            end
            if (update_en) begin
                if (xfer_long) begin
                    xfer_long <= 1'b0;
                    if (rd_dir) begin
                        reg_sel <= '0;
                    end else begin
                        wr_en   <= 1'b1;
                        wr_data <= sh_q;
                    end
                end else begin
                    exec_req <= cmd_go && !cmd_ex;
                    exit_req <= cmd_go && cmd_ex;
                    cnt_clr  <= dec.clr;
                    if (dec.hit) begin
                        if (access_ok) begin
                            xfer_long <= 1'b1;
                            rd_dir    <= cmd_rd;
                            reg_sel   <= sel_hot;
                        end else begin
                            err_flag <= 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dbg_cmd_port.sv
// Top of the debug command port: shifter, target decoder and command sequencer.
// Assumes: TAP strobes are synchronous to tck and one-hot; rd_data is a
// combinational function of reg_sel.
module dbg_cmd_port
    import dbg_pkg::*;
#(
    parameter int CMD_LEN  = CMD_W,
    parameter int DATA_LEN = DATA_W
) (
    input  logic                tck,
    input  logic                rst_n,
    input  logic                tdi,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                update_dr,
    input  logic                debug_mode,
    input  logic                fifo_halted,
    input  logic [DATA_LEN-1:0] rd_data,
    output logic                tdo,
    output logic                xfer_long,
    output logic [NREG-1:0]     reg_sel,
    output logic                wr_en,
    output logic [DATA_LEN-1:0] wr_data,
    output logic                exec_req,
    output logic                exit_req,
    output logic                cnt_clr,
    output logic                err_flag
);
    logic [DATA_LEN-1:0] sh_q;
    logic [DATA_LEN-1:0] load_val;
    logic                rd_dir;
    sel_dec_t            dec;

    // Capture loads read data only in a read data phase.
    assign load_val = (xfer_long && rd_dir) ? rd_data : '0;

    dbg_shifter #(.CMD_W(CMD_LEN), .DATA_W(DATA_LEN)) i_shift (
        .tck(tck), .rst_n(rst_n), .tdi(tdi),
        .capture_en(capture_dr), .shift_en(shift_dr), .long_mode(xfer_long),
        .load_val(load_val), .sh_q(sh_q), .tdo(tdo)
    );

    dbg_sel_decode i_dec (
        .code(sh_q[SEL_W-1:0]), .dec(dec)
    );

    dbg_cmd_ctrl #(.CMD_W(CMD_LEN), .DATA_W(DATA_LEN)) i_ctrl (
        .tck(tck), .rst_n(rst_n), .update_en(update_dr),
        .debug_mode(debug_mode), .fifo_halted(fifo_halted),
        .sh_q(sh_q), .dec(dec),
        .xfer_long(xfer_long), .rd_dir(rd_dir), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data),
        .exec_req(exec_req), .exit_req(exit_req), .cnt_clr(cnt_clr),
        .err_flag(err_flag)
    );
endmodule

// File: rtl/dbg_cmd_port_chk.sv
// Protocol checks on the debug command port outputs, bound to the top.
module dbg_cmd_port_chk
    import dbg_pkg::*;
(
    input logic            tck,
    input logic            rst_n,
    input logic            update_dr,
    input logic            xfer_long,
    input logic [NREG-1:0] reg_sel,
    input logic            wr_en,
    input logic            exec_req,
    input logic            exit_req,
    input logic            cnt_clr,
    input logic            err_flag
);
    assert_wr_after_update_R5: assert property (@(posedge tck) disable iff (!rst_n)
        wr_en |-> $past(update_dr));
    assert_wr_one_target_R5: assert property (@(posedge tck) disable iff (!rst_n)
        wr_en |-> $countones(reg_sel) == 1);
    assert_long_has_target_R3: assert property (@(posedge tck) disable iff (!rst_n)
        xfer_long |-> $countones(reg_sel) == 1);
    assert_go_exclusive_R6: assert property (@(posedge tck) disable iff (!rst_n)
        !(exec_req && exit_req));
    assert_clr_single_R7: assert property (@(posedge tck) disable iff (!rst_n)
        cnt_clr |=> !cnt_clr);
    assert_err_sticky_R9: assert property (@(posedge tck) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

bind dbg_cmd_port dbg_cmd_port_chk i_chk (
    .tck(tck), .rst_n(rst_n), .update_dr(update_dr), .xfer_long(xfer_long),
    .reg_sel(reg_sel), .wr_en(wr_en), .exec_req(exec_req), .exit_req(exit_req),
    .cnt_clr(cnt_clr), .err_flag(err_flag)
);

// File: tb/test_dbg_cmd_port.sv
module test_dbg_cmd_port;
    localparam int NR = 9;

    logic        tck = 1'b0;
    logic        rst_n = 1'b0;
    logic        tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic        debug_mode = 1'b0, fifo_halted = 1'b0;
    logic [15:0] rd_data;
    logic        tdo, xfer_long, wr_en, exec_req, exit_req, cnt_clr, err_flag;
    logic [NR-1:0] reg_sel;
    logic [15:0] wr_data;

    int total = 0;
    int bad = 0;

    // Scoreboard item: kind 0=clr 1=exec 2=exit 3=write.
    typedef struct { int kind; logic [NR-1:0] sel; logic [15:0] data; string req; } exp_t;
    exp_t expq[$];

    always #2 tck = ~tck;

    dbg_cmd_port i_dbg_cmd_port (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .debug_mode(debug_mode),
        .fifo_halted(fifo_halted), .rd_data(rd_data), .tdo(tdo),
        .xfer_long(xfer_long), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .exec_req(exec_req), .exit_req(exit_req), .cnt_clr(cnt_clr), .err_flag(err_flag)
    );

    // Register file model: value of target k is A000 + k*0111.
    function automatic logic [15:0] reg_val(int k);
        return 16'hA000 + 16'(k * 16'h0111);
    endfunction

    always_comb begin
        rd_data = 16'h0000;
        for (int k = 0; k < NR; k++) if (reg_sel[k]) rd_data = reg_val(k);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [NR-1:0] sel, input logic [15:0] d, input string req);
        exp_t e;
        e.kind = kind; e.sel = sel; e.data = d; e.req = req;
        expq.push_back(e);
    endtask

    // Compare one observed pulse against the queue head.
    task automatic observe(input int kind, input string req);
        exp_t e;
        if (expq.size() == 0) begin
            check(1'b0, req, kind, -1);
        end else begin
            e = expq.pop_front();
            if (kind == 3)
                check(e.kind == 3 && e.sel == reg_sel && e.data == wr_data, e.req,
                      {reg_sel, wr_data}, {e.sel, e.data});
            else
                check(e.kind == kind, e.req, kind, e.kind);
        end
    endtask

    // Monitor: pulses are stable at the falling edge.
    always @(negedge tck) begin
        if (rst_n) begin
            if (cnt_clr)  observe(0, "R7");
            if (exec_req) observe(1, "R6");
            if (exit_req) observe(2, "R6");
            if (wr_en)    observe(3, "R9");
        end
    end

    task automatic do_reset();
        @(negedge tck); rst_n = 1'b0;
        repeat (2) @(negedge tck);
        rst_n = 1'b1;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        @(negedge tck); capture_dr = 1'b1;
        @(negedge tck); capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < 8; i++) begin tdi = c[i]; @(negedge tck); end
        shift_dr = 1'b0; update_dr = 1'b1;
        @(negedge tck); update_dr = 1'b0;
        #1;
    endtask

    task automatic xfer16(input logic [15:0] din, output logic [15:0] dout);
        @(negedge tck); capture_dr = 1'b1;
        @(negedge tck); capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < 16; i++) begin
            tdi = din[i]; #1 dout[i] = tdo; @(negedge tck);
        end
        shift_dr = 1'b0; update_dr = 1'b1;
        @(negedge tck); update_dr = 1'b0;
        #1;
    endtask

    task automatic legal_read(input logic [7:0] c, input int k, input string req);
        logic [15:0] d;
        send_cmd(c);
        check(xfer_long && reg_sel == NR'(1 << k), req, {xfer_long, reg_sel}, {1'b1, NR'(1 << k)});
        xfer16(16'h0000, d);
        check(d == reg_val(k), req, d, reg_val(k));
        check(!xfer_long, "R3", xfer_long, 0);
    endtask

    task automatic legal_write(input logic [7:0] c, input int k, input logic [15:0] v, input string req);
        logic [15:0] d;
        send_cmd(c);
        check(xfer_long && reg_sel == NR'(1 << k), "R3", {xfer_long, reg_sel}, {1'b1, NR'(1 << k)});
        push(3, NR'(1 << k), v, req);
        xfer16(v, d);
        check(!xfer_long, "R3", xfer_long, 0);
    endtask

    task automatic rejected(input logic [7:0] c, input string req);
        send_cmd(c);
        check(!xfer_long && reg_sel == '0, req, {xfer_long, reg_sel}, 0);
        check(err_flag, req, err_flag, 1);
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        // R11 reset state
        check(!tdo && !err_flag && !xfer_long && reg_sel == '0, "R11",
              {tdo, err_flag, xfer_long, reg_sel}, 0);
        check(!wr_en && !exec_req && !exit_req && !cnt_clr, "R11",
              {wr_en, exec_req, exit_req, cnt_clr}, 0);

        // R5 R2 write control, then R1 R4 reads
        legal_write(8'h02, 1, 16'h1234, "R5");
        legal_write(8'h01, 0, 16'h8001, "R5");
        legal_read(8'h81, 0, "R1");
        legal_read(8'h82, 1, "R4");
        legal_write(8'h04, 2, 16'h00FF, "R5");

        // R7 counter clear action
        push(0, '0, 16'h0, "R7");
        send_cmd(8'h0C);
        check(!xfer_long, "R7", xfer_long, 0);

        // R8 none and reserved codes
        send_cmd(8'h00); check(!xfer_long && !err_flag, "R8", {xfer_long, err_flag}, 0);
        send_cmd(8'h83); check(!xfer_long && !err_flag, "R8", {xfer_long, err_flag}, 0);
        send_cmd(8'h17); check(!xfer_long && !err_flag, "R8", {xfer_long, err_flag}, 0);
        send_cmd(8'h1F); check(!xfer_long && !err_flag, "R8", {xfer_long, err_flag}, 0);

        // R6 execute and exit requests
        push(1, '0, 16'h0, "R6"); send_cmd(8'h40);
        push(2, '0, 16'h0, "R6"); send_cmd(8'h60);
        push(1, '0, 16'h0, "R6");
        legal_write(8'h42, 1, 16'h5A5A, "R6");
        push(2, '0, 16'h0, "R6");
        legal_read(8'hE1, 0, "R6");

        // R9 direction violations
        debug_mode = 1'b1; fifo_halted = 1'b1;
        rejected(8'h08, "R9");
        rejected(8'h84, "R9");
        rejected(8'h11, "R9");
        send_cmd(8'h02); check(xfer_long, "R9", xfer_long, 1);
        push(3, NR'(1 << 1), 16'h0F0F, "R5");
        begin logic [15:0] d; xfer16(16'h0F0F, d); end

        // R10 debug-mode gating
        do_reset();
        debug_mode = 1'b0;
        rejected(8'h88, "R10");
        rejected(8'h09, "R10");
        debug_mode = 1'b1;
        legal_read(8'h88, 3, "R10");
        legal_write(8'h09, 4, 16'hC3C3, "R10");

        // R10 FIFO-halt gating
        do_reset();
        fifo_halted = 1'b0;
        rejected(8'h90, "R10");
        rejected(8'h8A, "R10");
        fifo_halted = 1'b1;
        legal_read(8'h8A, 5, "R10");
        legal_read(8'h90, 6, "R10");
        legal_read(8'h91, 7, "R10");
        legal_read(8'h93, 8, "R10");

        repeat (3) @(negedge tck);
        check(expq.size() == 0, "R5", expq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule